// File: doc/BRIEF.md
# Single-Wire Pulse-Count Configuration Decoder

This block sits behind the control pin of a small audio power amplifier. The host drives a single, already synchronised line and sends commands as bursts of pulses. The block counts the rising edges in a burst. Once the line has stayed high long enough, it applies the count as one configuration command. A long low period switches the amplifier off. A rising edge while switched off wakes the amplifier and loads the power-on settings.

The outputs are plain control levels for the analog section: an amplifier enable, an automatic gain control enable, a gain select, a distortion-target code, a limiter mode and a peak-voltage code. A one-cycle strobe marks every applied command. No data stream crosses the block, so there is no valid/ready handshake. Every pin is a plain level or strobe. All timing thresholds are parameters counted in clock cycles. `SHDN_CYC` is the low-run length that means shutdown. `COMMIT_CYC` is the high-run length that applies a burst and must be at least 2. `CNT_W` is the pulse-counter width and must be at least 5.

Top module: `swire_cfg_decoder`

## Requirements
- R1: After reset the amplifier is off (`amp_en_o`=0) and `cfg_valid_o`=0. The configuration outputs hold the defaults: `agc_en_o`=1, `gain_hi_o`=1, `thd_sel_o`=0, `plim_en_o`=1 and `peak_sel_o`=7.
- R2: While the amplifier is off, a sampled rising edge of `line_i` sets `amp_en_o`=1 and reloads every default listed in R1 at that clock edge. That edge is not counted as a pulse and produces no strobe.
- R3: While enabled, each sampled rising edge of `line_i` adds one to the burst count. The count is applied on the edge where `line_i` has been sampled high for `COMMIT_CYC` consecutive cycles, provided the count is nonzero. On that edge the outputs update and `cfg_valid_o` is high for exactly one cycle. The count then restarts from zero.
- R4: A count of 1 clears `agc_en_o` and a count of 2 sets it. A count of 4 clears `gain_hi_o` (the lower gain) and a count of 5 sets it (the higher gain).
- R5: Counts 6 to 13 set `thd_sel_o` to count−6. The codes 0 to 7 stand for distortion targets of 1, 2, 4, 6, 8, 10, 15 and 20 percent.
- R6: A count of 14 sets `plim_en_o`=1, which selects non-clip plus power limit. A count of 15 sets `plim_en_o`=0, which selects non-clip only.
- R7: Counts 16 to 23 set `peak_sel_o` to count−16. Code k stands for a peak limit of (k+1)×0.45 V.
- R8: A count of 3 restores all the defaults of R1 and leaves `amp_en_o` unchanged.
- R9: A committed count above 23 strobes `cfg_valid_o` but changes no output. The counter saturates at 2^`CNT_W`−1. A burst of zero pulses commits nothing.
- R10: When `line_i` has been sampled low for `SHDN_CYC` consecutive cycles, `amp_en_o` goes to 0 at that edge. Any partly counted burst is dropped and the configuration outputs are kept. A low run shorter than this is an ordinary pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised control line |
| amp_en_o | output | 1 | Amplifier enable |
| agc_en_o | output | 1 | Automatic gain control enable |
| gain_hi_o | output | 1 | 1 = higher gain, 0 = lower gain |
| thd_sel_o | output | 3 | Distortion-target code |
| plim_en_o | output | 1 | 1 = non-clip plus power limit, 0 = non-clip only |
| peak_sel_o | output | 3 | Peak-voltage limit code |
| cfg_valid_o | output | 1 | One-cycle strobe on each applied command |

## Verification
The bench builds the block with `SHDN_CYC`=40, `COMMIT_CYC`=24 and `CNT_W`=5. These small values let the bench send every count from 1 to 31, each twice and in a scrambled order, within a short run. This covers every command, the out-of-range counts and counter saturation. The short windows also let the bench probe both sides of each threshold: a low run one cycle short of shutdown, and a high run one cycle short of commit. It also cuts a partly counted burst with a shutdown.

// File: rtl/swire_cfg_pkg.sv
`timescale 1ns/1ps
package swire_cfg_pkg;
  typedef struct packed {
    logic       agc_en;
    logic       gain_hi;
    logic [2:0] thd;
    logic       plim_en;
    logic [2:0] peak;
  } amp_cfg_t;

  localparam amp_cfg_t CFG_DEFAULT = '{agc_en: 1'b1, gain_hi: 1'b1, thd: 3'd0,
                                       plim_en: 1'b1, peak: 3'd7};

  // command boundaries; the pulse counts themselves are the protocol
  localparam int CMD_THD_LO  = 6;
  localparam int CMD_THD_HI  = 13;
  localparam int CMD_PEAK_LO = 16;
  localparam int CMD_PEAK_HI = 23;
endpackage

// File: rtl/swire_run_timer.sv
`timescale 1ns/1ps
module swire_run_timer #(
  parameter int SHDN_CYC   = 20000,
  parameter int COMMIT_CYC = 17500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o,
  output logic low_hit_o,
  output logic high_hit_o
);
  localparam int MAXL  = (SHDN_CYC > COMMIT_CYC) ? SHDN_CYC : COMMIT_CYC;
  localparam int RUN_W = $clog2(MAXL + 2);
  localparam logic [RUN_W-1:0] SAT    = RUN_W'(MAXL + 1);
  localparam logic [RUN_W-1:0] SHDN_V = RUN_W'(SHDN_CYC);
  localparam logic [RUN_W-1:0] COMM_V = RUN_W'(COMMIT_CYC);

  logic             line_q;
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    if (line_i != line_q) run_d = RUN_W'(1);
    else if (run_q == SAT) run_d = run_q;
    else run_d = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      run_q  <= '0;
    end else begin
      line_q <= line_i;
      run_q  <= run_d;
    end
  end

  assign rise_o     = line_i & ~line_q;
  assign low_hit_o  = ~line_i & (run_d == SHDN_V);
  assign high_hit_o = line_i & (run_d == COMM_V);

  // R3
  high_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_hit_o |-> (line_q && !rise_o));
endmodule

// File: rtl/swire_pulse_counter.sv
`timescale 1ns/1ps
module swire_pulse_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             rise_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (clear_i || !enable_i) count_q <= '0;
    else if (rise_i && count_q != CNT_MAX) count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_MAX) |=> (count_q == CNT_MAX || count_q == '0));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q) && count_q != '0) |-> (count_q == $past(count_q) + CNT_W'(1)));
endmodule

// File: rtl/swire_cfg_regs.sv
`timescale 1ns/1ps
module swire_cfg_regs
  import swire_cfg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             low_hit_i,
  input  logic             high_hit_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             enable_o,
  output amp_cfg_t         cfg_o,
  output logic             valid_o,
  output logic             drop_o
);
  logic     enable_q, valid_q;
  amp_cfg_t cfg_q, cfg_next;
  logic     wake, commit, shut;
  int       cmd;

  assign wake   = !enable_q && rise_i;
  assign commit = enable_q && high_hit_i && (count_i != '0);
  assign shut   = enable_q && low_hit_i;
  assign cmd    = int'(count_i);

  always_comb begin
    cfg_next = cfg_q;
    if (cmd == 1) cfg_next.agc_en = 1'b0;
    else if (cmd == 2) cfg_next.agc_en = 1'b1;
    else if (cmd == 3) cfg_next = CFG_DEFAULT;
    else if (cmd == 4) cfg_next.gain_hi = 1'b0;
    else if (cmd == 5) cfg_next.gain_hi = 1'b1;
    else if (cmd >= CMD_THD_LO && cmd <= CMD_THD_HI) cfg_next.thd = 3'(cmd - CMD_THD_LO);
    else if (cmd == 14) cfg_next.plim_en = 1'b1;
    else if (cmd == 15) cfg_next.plim_en = 1'b0;
    else if (cmd >= CMD_PEAK_LO && cmd <= CMD_PEAK_HI) cfg_next.peak = 3'(cmd - CMD_PEAK_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      cfg_q    <= CFG_DEFAULT;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= commit;
      if (wake) begin
        enable_q <= 1'b1;
        cfg_q    <= CFG_DEFAULT;
      end else begin
        if (shut) enable_q <= 1'b0;
        if (commit) cfg_q <= cfg_next;
      end
    end
  end

  assign enable_o = enable_q;
  assign cfg_o    = cfg_q;
  assign valid_o  = valid_q;
  assign drop_o   = shut || commit;

  // R10
  off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable_q) |-> $past(low_hit_i));
  // R10
  off_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable_q) |-> $stable(cfg_q));
  // R2
  wake_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable_q) |-> (cfg_q == CFG_DEFAULT && !valid_q));
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R3
  strobe_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> enable_q);
endmodule

// File: rtl/swire_cfg_decoder.sv
`timescale 1ns/1ps
module swire_cfg_decoder
  import swire_cfg_pkg::*;
#(
  parameter int SHDN_CYC   = 20000,
  parameter int COMMIT_CYC = 17500,
  parameter int CNT_W      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       amp_en_o,
  output logic       agc_en_o,
  output logic       gain_hi_o,
  output logic [2:0] thd_sel_o,
  output logic       plim_en_o,
  output logic [2:0] peak_sel_o,
  output logic       cfg_valid_o
);
  logic             rise, low_hit, high_hit, drop, enable;
  logic [CNT_W-1:0] count;
  amp_cfg_t         cfg;

  swire_run_timer #(.SHDN_CYC(SHDN_CYC), .COMMIT_CYC(COMMIT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .rise_o(rise), .low_hit_o(low_hit), .high_hit_o(high_hit)
  );

  swire_pulse_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .rise_i(rise),
    .clear_i(drop), .count_o(count)
  );

  swire_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .low_hit_i(low_hit),
    .high_hit_i(high_hit), .count_i(count), .enable_o(enable),
    .cfg_o(cfg), .valid_o(cfg_valid_o), .drop_o(drop)
  );

  assign amp_en_o   = enable;
  assign agc_en_o   = cfg.agc_en;
  assign gain_hi_o  = cfg.gain_hi;
  assign thd_sel_o  = cfg.thd;
  assign plim_en_o  = cfg.plim_en;
  assign peak_sel_o = cfg.peak;

  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && high_hit && int'(count) > CMD_PEAK_HI) |=> (cfg_valid_o && $stable(cfg)));
endmodule

// File: tb/swire_cfg_decoder_bench.sv
`timescale 1ns/1ps
module swire_cfg_decoder_bench;
  localparam int SHDN = 40;
  localparam int COMM = 24;
  localparam int PL   = 3;
  localparam int PH   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic amp_en, agc_en, gain_hi, plim_en, cfg_valid;
  logic [2:0] thd_sel, peak_sel;

  int total = 0;
  int bad = 0;
  int strobes = 0;

  logic       m_en, m_agc, m_gain, m_plim;
  int         m_thd, m_peak;

  always #2 clk = ~clk;

  swire_cfg_decoder #(.SHDN_CYC(SHDN), .COMMIT_CYC(COMM), .CNT_W(5)) u_swire_cfg_decoder (
    .clk(clk), .rst_n(rst_n), .line_i(line), .amp_en_o(amp_en), .agc_en_o(agc_en),
    .gain_hi_o(gain_hi), .thd_sel_o(thd_sel), .plim_en_o(plim_en),
    .peak_sel_o(peak_sel), .cfg_valid_o(cfg_valid)
  );

  always @(negedge clk) if (cfg_valid) strobes++;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic model_defaults();
    m_agc = 1; m_gain = 1; m_thd = 0; m_plim = 1; m_peak = 7;
  endtask

  task automatic model_apply(input int c);
    if (c == 1) m_agc = 0;
    else if (c == 2) m_agc = 1;
    else if (c == 3) model_defaults();
    else if (c == 4) m_gain = 0;
    else if (c == 5) m_gain = 1;
    else if (c >= 6 && c <= 13) m_thd = c - 6;
    else if (c == 14) m_plim = 1;
    else if (c == 15) m_plim = 0;
    else if (c >= 16 && c <= 23) m_peak = c - 16;
  endtask

  function automatic string tag_of(input int c);
    if (c == 3) return "R8";
    if (c <= 5) return "R4";
    if (c <= 13) return "R5";
    if (c <= 15) return "R6";
    if (c <= 23) return "R7";
    return "R9";
  endfunction

  task automatic check_all(input string tag);
    check({tag, " en"}, int'(amp_en), int'(m_en));
    check({tag, " agc"}, int'(agc_en), int'(m_agc));
    check({tag, " gain"}, int'(gain_hi), int'(m_gain));
    check({tag, " thd"}, int'(thd_sel), m_thd);
    check({tag, " plim"}, int'(plim_en), int'(m_plim));
    check({tag, " peak"}, int'(peak_sel), m_peak);
  endtask

  // n pulses; the last rising edge opens the commit window
  task automatic burst(input int n, input int low_len);
    for (int k = 0; k < n; k++) begin
      hold(1'b0, low_len);
      if (k != n - 1) hold(1'b1, PH);
    end
  endtask

  task automatic command(input int c);
    int s0;
    burst(c, PL);
    s0 = strobes;
    hold(1'b1, COMM - 1);
    check("R3 no early commit", strobes, s0);
    hold(1'b1, 1);
    check("R3 strobe at window end", int'(cfg_valid), 1);
    model_apply(c);
    hold(1'b1, 1);
    check("R3 strobe one cycle", int'(cfg_valid), 0);
    hold(1'b1, 2);
    check("R3 strobe count", strobes, s0 + 1);
    check_all(tag_of(c));
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    m_en = 0; model_defaults();
    repeat (3) @(negedge clk);
    check("R1 valid", int'(cfg_valid), 0);
    check_all("R1");
    rst_n = 1'b1;
    hold(1'b0, SHDN + 5);
    check_all("R1 still off");

    // wake; idle high with empty count commits nothing
    s0 = strobes;
    hold(1'b1, 1);
    m_en = 1;
    check_all("R2 wake");
    hold(1'b1, COMM + 6);
    check("R2 no strobe on wake", strobes, s0);

    // every count 1..31, twice, scrambled order
    for (int i = 0; i < 62; i++) command(((i * 7) % 31) + 1);

    // low run one short of shutdown is a pulse
    command(2);
    burst(1, SHDN - 1);
    hold(1'b1, COMM + 3);
    m_agc = 0;
    check_all("R10 short low is pulse");

    // shutdown cuts a partial burst
    command(19);
    command(10);
    s0 = strobes;
    burst(3, PL);
    hold(1'b1, PH);
    hold(1'b0, SHDN - 1);
    check("R10 not yet off", int'(amp_en), 1);
    hold(1'b0, 1);
    m_en = 0;
    check_all("R10 shutdown");
    hold(1'b0, SHDN);
    check("R10 no commit", strobes, s0);

    // wake restores defaults
    hold(1'b1, 1);
    m_en = 1; model_defaults();
    check_all("R2 rewake");
    hold(1'b1, COMM + 4);
    check("R2 rewake no strobe", strobes, s0);

    // reset command from a fully non-default state
    command(1); command(4); command(12); command(15); command(17);
    command(3);
    check_all("R8 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule